// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block turns a 30-bit virtual word address into a 30-bit physical word address. It reads page-table descriptors through a single-outstanding read port. A start strobe launches a walk. When translation is switched off, the address passes straight through. When it is on, the block reads a first-level descriptor. Depending on that descriptor's type, it either finishes with a section mapping or reads a second-level descriptor that maps a large or a small page.

All addresses are word addresses. Each descriptor base field therefore enters the address two bit positions lower than in a byte-addressed layout. The translation base and the virtual address are captured when a walk is accepted. The result sits on `paddr` and `fault` in the cycle `done` pulses, and stays there until the next result. Permission checks, domain checks and caching of translations or descriptors are not part of this block. It only reports whether a walk failed.

Top module: `pgw_walker`

## Requirements
- R1: While reset is held, `done`, `fault` and `mem_req` are 0 and `paddr` is 0.
- R2: A start accepted with `xlat_en` = 0 raises `done` on the next cycle with `fault` = 0, `paddr` equal to the captured `vaddr`, and no memory request.
- R3: The first-level descriptor is read at word address {tbase[17:0], vaddr[29:18]}. `mem_req` stays high with `mem_addr` unchanged until a cycle with `mem_rvalid` = 1.
- R4: A first-level descriptor with bits [1:0] = 2'b10 (section) ends the walk with `fault` = 0 and `paddr` = {desc[31:20], vaddr[17:0]}, after exactly one memory read.
- R5: A first-level descriptor with bits [1:0] = 2'b00 or 2'b11 ends the walk with `fault` = 1 and `paddr` = 0, after one read.
- R6: A first-level descriptor with bits [1:0] = 2'b01 (table) causes a second read at word address {desc[31:10], vaddr[17:10]}.
- R7: A second-level descriptor with bits [1:0] = 2'b01 (large page) gives `fault` = 0 and `paddr` = {desc[31:16], vaddr[13:0]}.
- R8: A second-level descriptor with bits [1:0] = 2'b10 or 2'b11 (small page) gives `fault` = 0 and `paddr` = {desc[31:12], vaddr[9:0]}.
- R9: A second-level descriptor with bits [1:0] = 2'b00 ends the walk with `fault` = 1 and `paddr` = 0.
- R10: A response with `mem_err` = 1 at either level ends the walk on the next cycle with `fault` = 1 and `paddr` = 0, and no further read is issued.
- R11: `done` is high for exactly one cycle per accepted start. A start is taken only while the walker is idle, so a start held through a walk, including its `done` cycle, launches nothing more.
- R12: Changes to `tbase` and `vaddr` after the start cycle do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable, sampled with start |
| tbase | input | 18 | Translation table base field |
| start | input | 1 | Launch a translation (taken only when idle) |
| vaddr | input | 30 | Virtual word address |
| mem_req | output | 1 | Read request, held until the response |
| mem_addr | output | 30 | Descriptor word address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Descriptor word |
| mem_err | input | 1 | Error flag qualifying the response |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed (valid with done) |
| paddr | output | 30 | Physical word address (0 on fault) |

## Verification
A new start request can coincide with a walk that is still running, including the very cycle in which `done` pulses and the state machine falls back to idle. The bench provokes this by holding `start` high from launch until it observes `done`. It then judges that only one `done` pulse appears, that no further memory request is raised in the following cycles, and that the read count matches a single walk. The memory model also answers on the first cycle a request is visible in some runs, so a response coincides with the request's first cycle. The bench then checks that the result and the read address are unaffected.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // Descriptor word width; word addresses are two bits narrower.
  localparam int DESC_W     = 32;
  // Bit positions of descriptor base fields (byte-address layout).
  localparam int SECT_LSB   = 20;
  localparam int TBL_LSB    = 10;
  localparam int LARGE_LSB  = 16;
  localparam int SMALL_LSB  = 12;
  // Word-address views of the same boundaries.
  localparam int L1_IDX_LSB = SECT_LSB - 2;
  localparam int L2_IDX_LSB = TBL_LSB;
  localparam int BASE_SHIFT = 12;

  typedef enum logic [1:0] {
    DK_FAULT,
    DK_NEXT,
    DK_BIG,
    DK_SMALL
  } dkind_e;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1_REQ,
    WS_L1_WAIT,
    WS_L2_REQ,
    WS_L2_WAIT,
    WS_DONE
  } wstate_e;
endpackage

// File: rtl/pgw_l1_decode.sv
module pgw_l1_decode
  import pgw_pkg::*;
#(
  parameter int DW = DESC_W,
  localparam int AW = DW - 2,
  localparam int TBW = AW - BASE_SHIFT
) (
  input  logic [TBW-1:0] tbase,
  input  logic [AW-1:0]  va,
  input  logic [DW-1:0]  desc,
  output logic [AW-1:0]  l1_addr,
  output dkind_e         kind,
  output logic [AW-1:0]  sect_pa,
  output logic [AW-1:0]  l2_addr
);
  always_comb begin
    l1_addr = {tbase, va[AW-1:L1_IDX_LSB]};
    sect_pa = {desc[DW-1:SECT_LSB], va[L1_IDX_LSB-1:0]};
    l2_addr = {desc[DW-1:TBL_LSB], va[L1_IDX_LSB-1:L2_IDX_LSB]};
    case (desc[1:0])
      2'b01:   kind = DK_NEXT;
      2'b10:   kind = DK_BIG;
      default: kind = DK_FAULT;
    endcase
  end
endmodule

// File: rtl/pgw_l2_decode.sv
module pgw_l2_decode
  import pgw_pkg::*;
#(
  parameter int DW = DESC_W,
  localparam int AW = DW - 2
) (
  input  logic [AW-1:0] va,
  input  logic [DW-1:0] desc,
  output dkind_e        kind,
  output logic [AW-1:0] leaf_pa
);
  logic [AW-1:0] large_pa;
  logic [AW-1:0] small_pa;

  always_comb begin
    large_pa = {desc[DW-1:LARGE_LSB], va[LARGE_LSB-3:0]};
    small_pa = {desc[DW-1:SMALL_LSB], va[SMALL_LSB-3:0]};
    case (desc[1:0])
      2'b00:   kind = DK_FAULT;
      2'b01:   kind = DK_BIG;
      default: kind = DK_SMALL;
    endcase
    leaf_pa = (kind == DK_BIG) ? large_pa : small_pa;
  end
endmodule

// File: rtl/pgw_req_port.sv
module pgw_req_port #(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic          rvalid,
  output logic          req,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      addr <= '0;
    end else if (issue) begin
      req  <= 1'b1;
      addr <= issue_addr;
    end else if (req && rvalid) begin
      req  <= 1'b0;
    end
  end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int DW = DESC_W,
  localparam int AW = DW - 2,
  localparam int TBW = AW - BASE_SHIFT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xlat_en,
  input  logic [TBW-1:0] tbase,
  input  logic           start,
  input  logic [AW-1:0]  vaddr,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_err,
  output logic           done,
  output logic           fault,
  output logic [AW-1:0]  paddr
);
  wstate_e        st_q, st_d;
  logic [TBW-1:0] tb_q;
  logic [AW-1:0]  va_q, l2a_q, pa_q;
  logic           flt_q;

  logic           walk_idle, take, rsp, issue;
  logic [AW-1:0]  l1_addr, sect_pa, l2_addr, leaf_pa, issue_addr;
  dkind_e         l1_kind, l2_kind;

  assign walk_idle = (st_q == WS_IDLE);
  assign take      = walk_idle && start;
  assign rsp       = mem_req && mem_rvalid;
  assign issue     = (st_q == WS_L1_REQ) || (st_q == WS_L2_REQ);
  assign issue_addr = (st_q == WS_L1_REQ) ? l1_addr : l2a_q;

  pgw_l1_decode #(.DW(DW)) u_l1 (
    .tbase  (tb_q),
    .va     (va_q),
    .desc   (mem_rdata),
    .l1_addr(l1_addr),
    .kind   (l1_kind),
    .sect_pa(sect_pa),
    .l2_addr(l2_addr)
  );

  pgw_l2_decode #(.DW(DW)) u_l2 (
    .va     (va_q),
    .desc   (mem_rdata),
    .kind   (l2_kind),
    .leaf_pa(leaf_pa)
  );

  pgw_req_port #(.AW(AW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .issue_addr(issue_addr),
    .rvalid    (mem_rvalid),
    .req       (mem_req),
    .addr      (mem_addr)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      WS_IDLE:    if (start) st_d = xlat_en ? WS_L1_REQ : WS_DONE;
      WS_L1_REQ:  st_d = WS_L1_WAIT;
      WS_L1_WAIT: if (rsp) st_d = (!mem_err && l1_kind == DK_NEXT) ? WS_L2_REQ : WS_DONE;
      WS_L2_REQ:  st_d = WS_L2_WAIT;
      WS_L2_WAIT: if (rsp) st_d = WS_DONE;
      WS_DONE:    st_d = WS_IDLE;
      default:    st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WS_IDLE;
      tb_q  <= '0;
      va_q  <= '0;
      l2a_q <= '0;
      pa_q  <= '0;
      flt_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take) begin
        tb_q <= tbase;
        va_q <= vaddr;
        if (!xlat_en) begin
          pa_q  <= vaddr;
          flt_q <= 1'b0;
        end
      end
      if (st_q == WS_L1_WAIT && rsp) begin
        if (mem_err) begin
          pa_q  <= '0;
          flt_q <= 1'b1;
        end else begin
          case (l1_kind)
            DK_BIG: begin
              pa_q  <= sect_pa;
              flt_q <= 1'b0;
            end
            DK_NEXT: l2a_q <= l2_addr;
            default: begin
              pa_q  <= '0;
              flt_q <= 1'b1;
            end
          endcase
        end
      end
      if (st_q == WS_L2_WAIT && rsp) begin
        if (mem_err || l2_kind == DK_FAULT) begin
          pa_q  <= '0;
          flt_q <= 1'b1;
        end else begin
          pa_q  <= leaf_pa;
          flt_q <= 1'b0;
        end
      end
    end
  end

  assign done  = (st_q == WS_DONE);
  assign fault = flt_q;
  assign paddr = pa_q;
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst,
  input logic          xlat_en,
  input logic          start,
  input logic [AW-1:0] vaddr,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          mem_err,
  input logic          done,
  input logic          fault,
  input logic [AW-1:0] paddr,
  input logic          walk_idle
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R3

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (walk_idle && start && !xlat_en) |=> (done && !fault && !mem_req && paddr == $past(vaddr))); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (paddr == '0)); // R5

  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid && mem_err) |=> (done && fault && !mem_req)); // R10

  AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
    (walk_idle && start && xlat_en) |=> (!done && !walk_idle)); // R11
endmodule

bind pgw_walker pgw_walker_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xlat_en   (xlat_en),
  .start     (start),
  .vaddr     (vaddr),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_rvalid(mem_rvalid),
  .mem_err   (mem_err),
  .done      (done),
  .fault     (fault),
  .paddr     (paddr),
  .walk_idle (walk_idle)
);

// File: tb/pgw_walker_tb_top.sv
`timescale 1ns/1ps
module pgw_walker_tb_top;
  localparam int DW  = 32;
  localparam int AW  = 30;
  localparam int TBW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic           xlat_en = 1'b0;
  logic [TBW-1:0] tbase = '0;
  logic           start = 1'b0;
  logic [AW-1:0]  vaddr = '0;
  logic           mem_req;
  logic [AW-1:0]  mem_addr;
  logic           mem_rvalid = 1'b0;
  logic [DW-1:0]  mem_rdata = '0;
  logic           mem_err = 1'b0;
  logic           done, fault;
  logic [AW-1:0]  paddr;

  pgw_walker dut_i (
    .clk(clk), .rst(rst), .xlat_en(xlat_en), .tbase(tbase), .start(start),
    .vaddr(vaddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .done(done), .fault(fault), .paddr(paddr)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Memory model state
  logic [DW-1:0] m_d1 = '0, m_d2 = '0;
  logic          m_e1 = 1'b0, m_e2 = 1'b0;
  int            m_lat = 0;
  int            acc = 0, wcnt = 0, unstable = 0;
  bit            in_req = 1'b0;
  logic [AW-1:0] cur_a = '0;
  logic [AW-1:0] seen_a [2];

  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (!rst && mem_req && !mem_rvalid) begin
      if (!in_req) begin
        in_req = 1'b1;
        cur_a  = mem_addr;
        wcnt   = 0;
      end else if (mem_addr !== cur_a) begin
        unstable++;
      end
      if (wcnt >= m_lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= (acc == 0) ? m_d1 : m_d2;
        mem_err    <= (acc == 0) ? m_e1 : m_e2;
        if (acc < 2) seen_a[acc] = cur_a;
        acc++;
        in_req = 1'b0;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input bit en, input logic [TBW-1:0] tb, input logic [AW-1:0] va,
                      input logic [DW-1:0] d1, input logic [DW-1:0] d2,
                      input bit e1, input bit e2, input int lat, input bit hold_start);
    logic [AW-1:0] e_l1, e_l2, e_pa;
    bit            e_f;
    int            e_acc;
    string         tg;
    int            cyc;
    e_l1 = {tb, va[29:18]};
    e_l2 = {d1[31:10], va[17:10]};
    if (!en) begin
      e_pa = va; e_f = 1'b0; e_acc = 0; tg = "R2";
    end else if (e1) begin
      e_pa = '0; e_f = 1'b1; e_acc = 1; tg = "R10";
    end else begin
      case (d1[1:0])
        2'b10: begin e_pa = {d1[31:20], va[17:0]}; e_f = 1'b0; e_acc = 1; tg = "R4"; end
        2'b01: begin
          e_acc = 2;
          if (e2) begin
            e_pa = '0; e_f = 1'b1; tg = "R10";
          end else begin
            case (d2[1:0])
              2'b00:   begin e_pa = '0; e_f = 1'b1; tg = "R9"; end
              2'b01:   begin e_pa = {d2[31:16], va[13:0]}; e_f = 1'b0; tg = "R7"; end
              default: begin e_pa = {d2[31:12], va[9:0]}; e_f = 1'b0; tg = "R8"; end
            endcase
          end
        end
        default: begin e_pa = '0; e_f = 1'b1; e_acc = 1; tg = "R5"; end
      endcase
    end
    m_d1 = d1; m_d2 = d2; m_e1 = e1; m_e2 = e2; m_lat = lat;
    acc = 0; unstable = 0;
    start = 1'b1; xlat_en = en; tbase = tb; vaddr = va;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    tbase = ~tb;  // R12: later input changes must not matter
    vaddr = ~va;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk({tg, " done seen"}, {31'd0, done}, 32'd1);
    chk({tg, " fault"}, {31'd0, fault}, {31'd0, e_f});
    chk({tg, "/R12 paddr"}, {2'b0, paddr}, {2'b0, e_pa});
    chk({tg, " read count"}, acc, e_acc);
    if (e_acc >= 1) chk("R3 first-level address", {2'b0, seen_a[0]}, {2'b0, e_l1});
    if (e_acc == 2) chk("R6 second-level address", {2'b0, seen_a[1]}, {2'b0, e_l2});
    chk("R3 address stable while requesting", unstable, 0);
    start = 1'b0;
    @(negedge clk);
    chk("R11 done single cycle", {31'd0, done}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || mem_req) chk("R11 no extra walk", {30'd0, done, mem_req}, 32'd0);
    end
    chk("R11 read count after quiet period", acc, e_acc);
  endtask

  function automatic logic [AW-1:0] va_of(input int i);
    case (i)
      0:       return 30'h0000_0000;
      1:       return 30'h3FFF_FFFF;
      2:       return 30'h0D2B_C6E5;
      default: return 30'h2AC5_1F3A;
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0]    p1, p2;
    logic [TBW-1:0] tbv;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset req", {31'd0, mem_req}, 32'd0);
    chk("R1 reset fault", {31'd0, fault}, 32'd0);
    chk("R1 reset paddr", {2'b0, paddr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int vi = 0; vi < 4; vi++) begin
      tbv = (vi % 2 == 1) ? 18'h2_A51C : 18'h0_00F3;
      p1  = 32'hC3A5_96F0 ^ (32'h0137_1DB4 * vi);
      p2  = 32'h5B2E_D138 ^ (32'h0A0B_0C0D * vi);
      walk(1'b0, tbv, va_of(vi), p1, p2, 1'b0, 1'b0, 0, vi[0]);  // R2
      for (int t1 = 0; t1 < 4; t1++) begin
        for (int t2 = 0; t2 < 4; t2++) begin
          if (t1 != 1 && t2 != 0) continue;
          walk(1'b1, tbv, va_of(vi), {p1[31:2], 2'(t1)}, {p2[31:2], 2'(t2)},
               1'b0, 1'b0, (vi + t1 + t2) % 4, (t2 == 3) || (t1 == 2 && vi[0]));
        end
      end
      walk(1'b1, tbv, va_of(vi), {p1[31:2], 2'b10}, p2, 1'b1, 1'b0, vi % 3, 1'b0);       // R10 first level
      walk(1'b1, tbv, va_of(vi), {p1[31:2], 2'b01}, {p2[31:2], 2'b10}, 1'b0, 1'b1, vi % 2, 1'b1); // R10 second level
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule